// File: doc/BRIEF.md
# While-Lower Loop Predicate Generator

This block builds the governing mask for one pass of a vectorised counted loop. It receives a running loop index and a loop bound, both unsigned 64-bit values, along with an element size and the vector length currently in force. Element `i` is marked active when the index plus `i` is still below the bound. The mask fills upward from element 0, and it stops at the first element that fails the test. Lanes past the active vector length stay off. Elements wider than a byte own several predicate bits each, and only the lowest of those bits carries the result.

Two condition flags come out beside the mask. One reports that element 0 is active, which tells the loop to continue. The other reports that no element is active, which tells the loop to exit. A single-cycle `start` strobe launches a computation. The mask, the flags and a `done` pulse are registered and appear one clock later. They hold steady until the next strobe.

The control is a two-state machine. `ST_IDLE` means no result was produced in the previous cycle, and `ST_DONE` means a result was produced in the previous cycle. The transitions are:
- launch: `ST_IDLE` to `ST_DONE` when `start` is high.
- relaunch: `ST_DONE` to `ST_DONE` when `start` is high again.
- retire: `ST_DONE` to `ST_IDLE` when `start` is low.

Top module: `wl_pred_gen`

## Requirements
- R1: Element `i` is active only if `{1'b0,loop_idx} + i < {1'b0,loop_bound}`, computed at 65 bits. An index plus offset that exceeds 2^64-1 never wraps around to pass the test.
- R2: The active elements form a contiguous run starting at element 0. Once one element fails, every higher-numbered element is inactive.
- R3: `elem_size` selects the element width: 0 for byte, 1 for 16-bit, 2 for 32-bit, 3 for 64-bit. Element `i` maps to predicate bit `i << elem_size`, and every other predicate bit is 0.
- R4: `vl_gran` gives the effective length in 128-bit granules. The element count is `(vl_gran*16) >> elem_size`. Elements at or past that count are inactive. Values above `MAX_VL_BITS/128` are clamped to that maximum, and 0 yields no active element.
- R5: `flag_first` is 1 exactly when element 0 of the result is active.
- R6: `flag_none` is 1 exactly when no element of the result is active.
- R7: A `start` sampled high at a rising edge loads the mask and flags at that edge. `done` is high during the following cycle, and only in that cycle. Back-to-back strobes give back-to-back results.
- R8: Without `start`, changes on `loop_idx`, `loop_bound`, `elem_size` and `vl_gran` have no effect. The mask and the flags keep their last values.
- R9: After reset the mask is all zero, `flag_first` is 0, `flag_none` is 1 and `done` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Launch strobe; operands are sampled on the same edge |
| loop_idx | input | 64 | Unsigned first scalar (running index) |
| loop_bound | input | 64 | Unsigned second scalar (bound) |
| elem_size | input | 2 | Element size code (R3) |
| vl_gran | input | $clog2(MAX_VL_BITS/128+1) | Effective vector length in 128-bit granules |
| pred_out | output | MAX_VL_BITS/8 | Byte-granular predicate |
| flag_first | output | 1 | Element 0 active |
| flag_none | output | 1 | No element active |
| done | output | 1 | Result produced by the previous cycle's strobe |

## Verification
Every result is due exactly one rising edge after the edge that samples `start`. The bench drives operands and `start` on a falling edge, then reads the mask, both flags and `done` on the next falling edge, which lies halfway between the loading edge and the one after it. For back-to-back strobes it reads each result on the falling edge that follows its own loading edge. The hold checks change operands with `start` low, then read the outputs two falling edges later, after `done` has dropped.

// File: rtl/wl_pkg.sv
package wl_pkg;

    typedef enum logic [1:0] {
        ESZ_B = 2'd0,
        ESZ_H = 2'd1,
        ESZ_W = 2'd2,
        ESZ_D = 2'd3
    } esz_t;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_DONE = 1'b1
    } wl_state_t;

endpackage

// File: rtl/wl_lane_cmp.sv
module wl_lane_cmp #(
    parameter int XW  = 64,
    parameter int IDX = 0
) (
    input  logic [XW-1:0] idx_in,
    input  logic [XW-1:0] bound_in,
    output logic          below
);
    logic [XW:0] sum_w;

    always_comb begin
        sum_w = {1'b0, idx_in} + (XW+1)'(IDX);
        below = sum_w < {1'b0, bound_in};
    end
endmodule

// File: rtl/wl_mask_build.sv
module wl_mask_build
    import wl_pkg::*;
#(
    parameter int NE        = 32,
    parameter int MAX_GRAN  = 2,
    parameter int GW        = 2,
    parameter int CW        = 6
) (
    input  logic [NE-1:0] below,
    input  esz_t          esz,
    input  logic [GW-1:0] gran,
    output logic [NE-1:0] act,
    output logic [CW-1:0] lim_bytes
);
    localparam int GRAN_BYTES = 16;

    logic [GW-1:0] gran_c;
    logic [CW-1:0] n_elem;
    logic          run;

    always_comb begin
        gran_c    = (gran > GW'(MAX_GRAN)) ? GW'(MAX_GRAN) : gran;
        lim_bytes = CW'(gran_c) * CW'(GRAN_BYTES);
        n_elem    = lim_bytes >> esz;
        run       = 1'b1;
        for (int i = 0; i < NE; i++) begin
            run    = run & below[i] & (CW'(i) < n_elem);
            act[i] = run;
        end
    end
endmodule

// File: rtl/wl_place.sv
module wl_place
    import wl_pkg::*;
#(
    parameter int NE = 32
) (
    input  logic [NE-1:0] act,
    input  esz_t          esz,
    output logic [NE-1:0] pred
);
    for (genvar j = 0; j < NE; j++) begin : g_bit
        localparam bit H_OK = (j % 2) == 0;
        localparam bit W_OK = (j % 4) == 0;
        localparam bit D_OK = (j % 8) == 0;
        localparam int H_IX = j / 2;
        localparam int W_IX = j / 4;
        localparam int D_IX = j / 8;

        always_comb begin
            unique case (esz)
                ESZ_B: pred[j] = act[j];
                ESZ_H: pred[j] = H_OK ? act[H_IX] : 1'b0;
                ESZ_W: pred[j] = W_OK ? act[W_IX] : 1'b0;
                ESZ_D: pred[j] = D_OK ? act[D_IX] : 1'b0;
                default: pred[j] = 1'b0;
            endcase
        end
    end
endmodule

// File: rtl/wl_pred_gen.sv
module wl_pred_gen
    import wl_pkg::*;
#(
    parameter int MAX_VL_BITS = 256,
    parameter int XW          = 64,
    localparam int PRED_W     = MAX_VL_BITS / 8,
    localparam int MAX_GRAN   = MAX_VL_BITS / 128,
    localparam int GW         = $clog2(MAX_GRAN + 1),
    localparam int CW         = $clog2(PRED_W + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [XW-1:0]     loop_idx,
    input  logic [XW-1:0]     loop_bound,
    input  logic [1:0]        elem_size,
    input  logic [GW-1:0]     vl_gran,
    output logic [PRED_W-1:0] pred_out,
    output logic              flag_first,
    output logic              flag_none,
    output logic              done
);
    function automatic logic [PRED_W-1:0] odd_bits();
        logic [PRED_W-1:0] m;
        for (int j = 0; j < PRED_W; j++) m[j] = (j % 2) == 1;
        return m;
    endfunction

    localparam logic [PRED_W-1:0] ODD_MASK = odd_bits();

    esz_t              esz_in;
    logic [PRED_W-1:0] below;
    logic [PRED_W-1:0] act;
    logic [PRED_W-1:0] pred_nx;
    logic [CW-1:0]     lim_nx;

    wl_state_t         state, state_nx;
    esz_t              esz_q;
    logic [CW-1:0]     lim_q;

    assign esz_in = esz_t'(elem_size);

    for (genvar i = 0; i < PRED_W; i++) begin : g_lane
        wl_lane_cmp #(.XW(XW), .IDX(i)) u_cmp (
            .idx_in   (loop_idx),
            .bound_in (loop_bound),
            .below    (below[i])
        );
    end

    wl_mask_build #(
        .NE(PRED_W), .MAX_GRAN(MAX_GRAN), .GW(GW), .CW(CW)
    ) u_mask (
        .below     (below),
        .esz       (esz_in),
        .gran      (vl_gran),
        .act       (act),
        .lim_bytes (lim_nx)
    );

    wl_place #(.NE(PRED_W)) u_place (
        .act  (act),
        .esz  (esz_in),
        .pred (pred_nx)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // Transitions: launch, relaunch, retire
    always_comb begin
        unique case (state)
            ST_IDLE: state_nx = start ? ST_DONE : ST_IDLE;
            ST_DONE: state_nx = start ? ST_DONE : ST_IDLE;
            default: state_nx = ST_IDLE;
        endcase
    end

    // Output registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pred_out   <= '0;
            flag_first <= 1'b0;
            flag_none  <= 1'b1;
            esz_q      <= ESZ_B;
            lim_q      <= '0;
        end else if (start) begin
            pred_out   <= pred_nx;
            flag_first <= act[0];
            flag_none  <= ~|act;
            esz_q      <= esz_in;
            lim_q      <= lim_nx;
        end
    end

    assign done = (state == ST_DONE);

    assert_done_after_start_R7: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> done);
    assert_done_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(start));
    assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !start |=> ($stable(pred_out) && $stable(flag_first) && $stable(flag_none)));
    assert_first_R5: assert property (@(posedge clk) disable iff (!rst_n)
        flag_first == pred_out[0]);
    assert_none_R6: assert property (@(posedge clk) disable iff (!rst_n)
        flag_none == (pred_out == '0));
    assert_sparse_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (esz_q != ESZ_B) |-> ((pred_out & ODD_MASK) == '0));
    assert_vl_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (pred_out >> lim_q) == '0);
endmodule

// File: tb/tb_wl_pred_gen.sv
`timescale 1ns/1ps
module tb_wl_pred_gen;
    localparam int PW = 32;
    localparam int MG = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [63:0]   loop_idx = '0;
    logic [63:0]   loop_bound = '0;
    logic [1:0]    elem_size = '0;
    logic [1:0]    vl_gran = '0;
    logic [PW-1:0] pred_out;
    logic          flag_first, flag_none, done;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    wl_pred_gen #(.MAX_VL_BITS(256)) dut (
        .clk(clk), .rst_n(rst_n), .start(start),
        .loop_idx(loop_idx), .loop_bound(loop_bound),
        .elem_size(elem_size), .vl_gran(vl_gran),
        .pred_out(pred_out), .flag_first(flag_first),
        .flag_none(flag_none), .done(done)
    );

    function automatic logic [PW-1:0] model(logic [63:0] a, logic [63:0] b,
                                            int es, int vl);
        logic [PW-1:0] p = '0;
        int g = (vl > MG) ? MG : vl;
        int nel = (g * 16) >> es;
        bit run = 1;
        for (int i = 0; i < PW; i++) begin
            logic [64:0] s = {1'b0, a} + 65'(i);
            run = run && (i < nel) && (s < {1'b0, b});
            if (run && ((i << es) < PW)) p[i << es] = 1'b1;
        end
        return p;
    endfunction

    task automatic chk(bit ok, string req, logic [PW-1:0] act, logic [PW-1:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic check_result(logic [63:0] a, logic [63:0] b, int es, int vl, string req);
        logic [PW-1:0] e = model(a, b, es, vl);
        chk(pred_out == e, req, pred_out, e);
        chk(flag_first == e[0], "R5", PW'(flag_first), PW'(e[0]));
        chk(flag_none == (e == '0), "R6", PW'(flag_none), PW'(e == '0));
        chk(done == 1'b1, "R7", PW'(done), PW'(1));
    endtask

    task automatic run_op(logic [63:0] a, logic [63:0] b, int es, int vl, string req);
        @(negedge clk);
        loop_idx = a; loop_bound = b; elem_size = 2'(es); vl_gran = 2'(vl); start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check_result(a, b, es, vl, req);
    endtask

    task automatic report();
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog actual=timeout expected=completion");
            report();
        end
    end

    initial begin
        logic [63:0] bases [5];
        logic [PW-1:0] held;
        bases[0] = 64'd0;
        bases[1] = 64'd5;
        bases[2] = 64'h7FFF_FFFF_FFFF_FFF0;
        bases[3] = 64'hFFFF_FFFF_FFFF_FFF8;
        bases[4] = 64'hFFFF_FFFF_FFFF_FFFF;

        repeat (3) @(negedge clk);
        // R9: reset state
        chk(pred_out == '0, "R9", pred_out, '0);
        chk(flag_first == 1'b0, "R9", PW'(flag_first), '0);
        chk(flag_none == 1'b1, "R9", PW'(flag_none), PW'(1));
        chk(done == 1'b0, "R9", PW'(done), '0);
        rst_n = 1'b1;

        // R1 R2 R3 R4: sweep of sizes, lengths, bases and distances
        for (int e = 0; e < 4; e++)
            for (int v = 0; v < 4; v++)
                for (int k = 0; k < 5; k++)
                    for (int d = -3; d < 37; d++)
                        run_op(bases[k], bases[k] + 64'(d), e, v, "R1_R2_R3_R4");

        // R1 R2: no wrap of index plus offset near the top of the range
        for (int e = 0; e < 4; e++) begin
            run_op(64'hFFFF_FFFF_FFFF_FFF6, 64'hFFFF_FFFF_FFFF_FFFF, e, 2, "R1");
            run_op(64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, e, 2, "R2");
            run_op(64'hFFFF_FFFF_FFFF_FFF0, 64'd3, e, 2, "R2");
        end

        // R7: back-to-back strobes
        @(negedge clk);
        loop_idx = 64'd0; loop_bound = 64'd7; elem_size = 2'd0; vl_gran = 2'd2; start = 1'b1;
        @(negedge clk);
        check_result(64'd0, 64'd7, 0, 2, "R7");
        loop_idx = 64'd10; loop_bound = 64'd13; elem_size = 2'd1;
        @(negedge clk);
        start = 1'b0;
        check_result(64'd10, 64'd13, 1, 2, "R7");

        // R8: inputs ignored without start
        held = pred_out;
        loop_idx = 64'd0; loop_bound = 64'd100; elem_size = 2'd0; vl_gran = 2'd2;
        @(negedge clk);
        @(negedge clk);
        chk(pred_out == held, "R8", pred_out, held);
        chk(done == 1'b0, "R8", PW'(done), '0);
        chk(flag_first == held[0], "R8", PW'(flag_first), PW'(held[0]));
        chk(flag_none == (held == '0), "R8", PW'(flag_none), PW'(held == '0));

        report();
    end
endmodule